// File: doc/BRIEF.md
# Register File with Microcode Temporary

A 16-bit register file for a multi-cycle datapath. It holds eight architectural registers, R0 to R7, and a ninth register, R8, that only the microprogram can reach. R8 keeps intermediate results between the micro-steps of one instruction. The file has one write port and two combinational read ports. The read ports drive the A and B operand buses.

Each port is addressed by a 3-bit register field taken from the instruction, plus one control-word bit placed above that field. When the control-word bit is 0, the field selects R0 to R7 directly. When it is 1, the port selects R8 and the field is ignored. Writes take effect on the rising clock edge. Reads always show the contents stored before that edge.

Top module: `tmp_regfile`

## Requirements
- R1: A synchronous active-high `rst` clears all nine registers to 0 at the clock edge, and reset takes priority over a write in the same cycle.
- R2: With `wr_en`=1 and `wr_tmp`=0, the rising edge stores `wr_data` into register `wr_field` (0 to 7).
- R3: With `wr_en`=0, no register changes at the edge, whatever the other write inputs are.
- R4: With `wr_en`=1 and `wr_tmp`=1, the edge stores `wr_data` into R8 for any `wr_field` value, and R0 to R7 keep their contents.
- R5: `bus_a` shows register `a_field` when `a_tmp`=0 and shows R8 when `a_tmp`=1, for any `a_field` value. No clock edge is needed for the output to follow.
- R6: `bus_b` follows the same rule, using `b_tmp` and `b_field`.
- R7: A read of the register being written in the current cycle returns the old value until the edge, and returns the new value after it.
- R8: Both read ports may select the same register, R8 included, at the same time, and each returns that register's contents.
- R9: All 16 data bits are stored and returned unchanged, including the patterns 0xFFFF and 0x8001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable from the control word |
| wr_tmp | input | 1 | Control-word bit above the destination field; 1 selects R8 |
| wr_field | input | 3 | Destination register field from the instruction |
| wr_data | input | 16 | Data to write |
| a_tmp | input | 1 | Control-word bit above the A field; 1 selects R8 |
| a_field | input | 3 | A-port register field from the instruction |
| b_tmp | input | 1 | Control-word bit above the B field; 1 selects R8 |
| b_field | input | 3 | B-port register field from the instruction |
| bus_a | output | 16 | Contents of the register selected for port A |
| bus_b | output | 16 | Contents of the register selected for port B |

## Verification
The bench targets four faults:

- **Temporary bit ignored.** The bench writes and reads R8 with non-zero low fields. A design that ignored the extra bit would overwrite or return R0 to R7 instead of R8.
- **Low field not ignored.** The bench sets the destination field to 3 while writing R8, then reads back R3. A design that decoded the low bits alongside the temporary bit would corrupt R3.
- **Write forwarding.** The bench reads a register before and after the edge that writes it. A design that forwarded the incoming data would show the new value one cycle early.
- **Reset and write handling.** The bench asserts reset in the middle of a run, and it applies writes with the enable low. A design that dropped the priority of reset, or that wrote without the enable, would leave non-zero values behind.

// File: rtl/rf_pkg.sv
package rf_pkg;

  // Roles of the three register-file ports; used to index per-port arrays.
  typedef enum logic [1:0] {
    RF_PORT_WR = 2'd0,
    RF_PORT_A  = 2'd1,
    RF_PORT_B  = 2'd2
  } rf_port_e;

  localparam int RF_NUM_PORTS = 3;

endpackage

// File: rtl/rf_addr_map.sv
// Forms a physical register index from a control-word select bit and an
// instruction register field. A set select bit always maps to the temporary.
module rf_addr_map #(
  parameter int FIELD_W = 3,
  parameter int IDX_W   = 4,
  parameter int TMP_IDX = 8
) (
  input  logic               tmp_sel,
  input  logic [FIELD_W-1:0] field,
  output logic [IDX_W-1:0]   idx
);

  always_comb begin
    if (tmp_sel) idx = IDX_W'(TMP_IDX);
    else         idx = IDX_W'(field);
  end

endmodule

// File: rtl/rf_storage.sv
// Register array with one synchronous write port and synchronous reset.
// All contents are exposed so read ports can select combinationally.
module rf_storage #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 9,
  parameter int IDX_W    = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);

  logic [NUM_REGS-1:0][DATA_W-1:0] mem;
  logic                            idx_ok;

  assign idx_ok = (wr_idx < IDX_W'(NUM_REGS));

  always_ff @(posedge clk) begin
    if (rst) begin
      mem <= '0;
    end else if (wr_en && idx_ok) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign regs_q = mem;

  // R1: one edge after reset was sampled, the whole array is zero.
  p_reset_clears_r1: assert property (@(posedge clk)
    $past(rst) |-> (mem == '0));

  // R3: without a write enable nothing in the array moves.
  p_hold_no_write_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mem));

  // R2: an enabled write lands at the addressed slot one edge later.
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx_ok) |=> (mem[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/rf_read_port.sv
// Combinational read selector over the full register array.
module rf_read_port #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 9,
  parameter int IDX_W    = 4
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  input  logic [IDX_W-1:0]                rd_idx,
  output logic [DATA_W-1:0]               rd_data
);

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = regs[i];
    end
  end

endmodule

// File: rtl/tmp_regfile.sv
// Register file: architectural registers plus one microcode temporary.
module tmp_regfile
  import rf_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int FIELD_W  = 3,
  localparam int NUM_ARCH = 1 << FIELD_W,
  localparam int NUM_REGS = NUM_ARCH + 1,
  localparam int TMP_IDX  = NUM_ARCH,
  localparam int IDX_W    = FIELD_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_tmp,
  input  logic [FIELD_W-1:0] wr_field,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               a_tmp,
  input  logic [FIELD_W-1:0] a_field,
  input  logic               b_tmp,
  input  logic [FIELD_W-1:0] b_field,
  output logic [DATA_W-1:0]  bus_a,
  output logic [DATA_W-1:0]  bus_b
);

  logic [RF_NUM_PORTS-1:0]                tmp_bits;
  logic [FIELD_W-1:0]                     fields   [RF_NUM_PORTS];
  logic [IDX_W-1:0]                       port_idx [RF_NUM_PORTS];
  logic [DATA_W-1:0]                      rd_data  [RF_NUM_PORTS-1:1];
  logic [NUM_REGS-1:0][DATA_W-1:0]        regs_q;

  assign tmp_bits[int'(RF_PORT_WR)] = wr_tmp;
  assign tmp_bits[int'(RF_PORT_A)]  = a_tmp;
  assign tmp_bits[int'(RF_PORT_B)]  = b_tmp;
  assign fields[int'(RF_PORT_WR)]   = wr_field;
  assign fields[int'(RF_PORT_A)]    = a_field;
  assign fields[int'(RF_PORT_B)]    = b_field;

  // One address mapper per port.
  for (genvar p = 0; p < RF_NUM_PORTS; p++) begin : g_map
    rf_addr_map #(
      .FIELD_W (FIELD_W),
      .IDX_W   (IDX_W),
      .TMP_IDX (TMP_IDX)
    ) u_map (
      .tmp_sel (tmp_bits[p]),
      .field   (fields[p]),
      .idx     (port_idx[p])
    );
  end

  rf_storage #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (port_idx[int'(RF_PORT_WR)]),
    .wr_data (wr_data),
    .regs_q  (regs_q)
  );

  // Read ports: every port role except the write port.
  for (genvar p = 1; p < RF_NUM_PORTS; p++) begin : g_rd
    rf_read_port #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS),
      .IDX_W    (IDX_W)
    ) u_rd (
      .regs    (regs_q),
      .rd_idx  (port_idx[p]),
      .rd_data (rd_data[p])
    );
  end

  assign bus_a = rd_data[int'(RF_PORT_A)];
  assign bus_b = rd_data[int'(RF_PORT_B)];

  // R4: a write aimed at the temporary leaves every architectural register intact.
  p_tmp_write_spares_arch_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_tmp) |=> $stable(regs_q[NUM_ARCH-1:0]));

  // R5: with the A select bit set, the A bus carries the temporary.
  p_tmp_read_a_r5: assert property (@(posedge clk) disable iff (rst)
    a_tmp |-> (bus_a == regs_q[TMP_IDX]));

  // R6: with the B select bit set, the B bus carries the temporary.
  p_tmp_read_b_r6: assert property (@(posedge clk) disable iff (rst)
    b_tmp |-> (bus_b == regs_q[TMP_IDX]));

endmodule

// File: tb/tmp_regfile_tb.sv
`timescale 1ns/1ps
module tmp_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, wr_tmp, a_tmp, b_tmp;
  logic [2:0]  wr_field, a_field, b_field;
  logic [15:0] wr_data;
  logic [15:0] bus_a, bus_b;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [15:0] model [9];

  always #2.5 clk = ~clk;

  tmp_regfile dut_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_tmp   (wr_tmp),
    .wr_field (wr_field),
    .wr_data  (wr_data),
    .a_tmp    (a_tmp),
    .a_field  (a_field),
    .b_tmp    (b_tmp),
    .b_field  (b_field),
    .bus_a    (bus_a),
    .bus_b    (bus_b)
  );

  typedef struct packed {
    logic        we;
    logic        td;
    logic [2:0]  ds;
    logic [15:0] dat;
    logic        ta;
    logic [2:0]  as;
    logic        tb;
    logic [2:0]  bs;
  } vec_t;

  function automatic vec_t mk(logic we, logic td, logic [2:0] ds, logic [15:0] dat,
                              logic ta, logic [2:0] as, logic tb, logic [2:0] bs);
    vec_t v;
    v.we = we; v.td = td; v.ds = ds; v.dat = dat;
    v.ta = ta; v.as = as; v.tb = tb; v.bs = bs;
    return v;
  endfunction

  // Each row: write controls, then A and B read selects.
  localparam vec_t VECS [12] = '{
    mk(1, 0, 3'd0, 16'h1111, 0, 3'd0, 0, 3'd0),
    mk(1, 0, 3'd1, 16'h2222, 0, 3'd0, 0, 3'd1),
    mk(1, 0, 3'd7, 16'hFFFF, 0, 3'd1, 0, 3'd0),
    mk(1, 1, 3'd3, 16'h8888, 0, 3'd3, 0, 3'd7),
    mk(0, 0, 3'd3, 16'hDEAD, 1, 3'd0, 0, 3'd3),
    mk(1, 0, 3'd2, 16'hA5A5, 0, 3'd2, 1, 3'd6),
    mk(1, 1, 3'd0, 16'h0001, 1, 3'd7, 0, 3'd2),
    mk(0, 1, 3'd5, 16'h7777, 1, 3'd2, 1, 3'd1),
    mk(1, 0, 3'd4, 16'h8000, 0, 3'd4, 0, 3'd4),
    mk(0, 0, 3'd4, 16'h0000, 0, 3'd4, 0, 3'd7),
    mk(1, 0, 3'd6, 16'h1234, 0, 3'd1, 0, 3'd2),
    mk(0, 0, 3'd0, 16'h0000, 0, 3'd6, 1, 3'd0)
  };

  function automatic int sel(logic t, logic [2:0] f);
    return t ? 8 : int'(f);
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Drive all inputs, then let combinational reads settle.
  task automatic drive(logic we, logic td, logic [2:0] ds, logic [15:0] dat,
                       logic ta, logic [2:0] as, logic tb, logic [2:0] bs);
    wr_en = we; wr_tmp = td; wr_field = ds; wr_data = dat;
    a_tmp = ta; a_field = as; b_tmp = tb; b_field = bs;
    #1;
  endtask

  // One clock edge; the model follows the requirements, then back to mid-cycle.
  task automatic tick();
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < 9; i++) model[i] = 16'h0000;
    end else if (wr_en) begin
      model[sel(wr_tmp, wr_field)] = wr_data;
    end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    for (int i = 0; i < 9; i++) model[i] = 16'hXXXX;
    drive(1, 0, 3'd2, 16'hBAD0, 0, 3'd0, 0, 3'd0);
    tick();
    tick();
    rst = 1'b0;
    drive(0, 0, 3'd0, 16'h0000, 0, 3'd0, 0, 3'd0);

    // R1: every register, R8 included, reads zero after reset.
    for (int r = 0; r < 9; r++) begin
      drive(0, 0, 3'd0, 16'h0000, r == 8, 3'(r), r == 8, 3'(7 - r));
      chk("R1 port A", bus_a, 16'h0000);
      chk("R1 port B", bus_b, 16'h0000);
    end

    // Vector table: R5 and R6 read checks, taken before each edge.
    for (int v = 0; v < 12; v++) begin
      drive(VECS[v].we, VECS[v].td, VECS[v].ds, VECS[v].dat,
            VECS[v].ta, VECS[v].as, VECS[v].tb, VECS[v].bs);
      chk("R5 vector bus_a", bus_a, model[sel(VECS[v].ta, VECS[v].as)]);
      chk("R6 vector bus_b", bus_b, model[sel(VECS[v].tb, VECS[v].bs)]);
      tick();
    end

    // R2: a plain write to R3.
    drive(1, 0, 3'd3, 16'h5A5A, 0, 3'd3, 0, 3'd0);
    tick();
    drive(0, 0, 3'd0, 16'h0000, 0, 3'd3, 0, 3'd0);
    chk("R2 write R3", bus_a, 16'h5A5A);

    // R3: enable low, every other write input active.
    drive(0, 1, 3'd3, 16'h0F0F, 0, 3'd3, 1, 3'd3);
    tick();
    chk("R3 R3 unchanged", bus_a, 16'h5A5A);
    chk("R3 R8 unchanged", bus_b, model[8]);

    // R4: a temporary write with low field 3 must not touch R3.
    drive(1, 1, 3'd3, 16'hC3C3, 0, 3'd3, 1, 3'd3);
    tick();
    drive(0, 0, 3'd0, 16'h0000, 0, 3'd3, 1, 3'd5);
    chk("R4 R3 kept", bus_a, 16'h5A5A);
    chk("R4 R8 written", bus_b, 16'hC3C3);

    // R7: same-cycle read returns the old value, then the new one.
    drive(1, 0, 3'd1, 16'hBEEF, 0, 3'd1, 0, 3'd1);
    chk("R7 before edge A", bus_a, model[1]);
    chk("R7 before edge B", bus_b, model[1]);
    tick();
    drive(0, 0, 3'd0, 16'h0000, 0, 3'd1, 0, 3'd0);
    chk("R7 after edge", bus_a, 16'hBEEF);

    // R8: both ports select the temporary, using different low fields.
    drive(0, 0, 3'd0, 16'h0000, 1, 3'd6, 1, 3'd2);
    chk("R8 both A", bus_a, 16'hC3C3);
    chk("R8 both B", bus_b, 16'hC3C3);

    // R9: full-width data patterns.
    drive(1, 0, 3'd7, 16'h8001, 0, 3'd0, 0, 3'd0);
    tick();
    drive(1, 1, 3'd0, 16'hFFFF, 0, 3'd7, 0, 3'd7);
    chk("R9 0x8001 A", bus_a, 16'h8001);
    tick();
    drive(0, 0, 3'd0, 16'h0000, 1, 3'd0, 0, 3'd7);
    chk("R9 0xFFFF", bus_a, 16'hFFFF);
    chk("R9 0x8001 B", bus_b, 16'h8001);

    // R1: reset in mid-run wins over a write in the same cycle.
    rst = 1'b1;
    drive(1, 0, 3'd3, 16'h4444, 0, 3'd0, 0, 3'd0);
    tick();
    rst = 1'b0;
    drive(0, 0, 3'd0, 16'h0000, 0, 3'd3, 1, 3'd0);
    chk("R1 mid-run R3", bus_a, 16'h0000);
    chk("R1 mid-run R8", bus_b, 16'h0000);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule